// File: doc/BRIEF.md
# Supervisor Domain External Interrupt CSR Block

This block keeps the machine-level state for external interrupts that belong to supervisor domains. It takes one pending line from each of N supervisor-domain interrupt controllers. It holds an enable vector for those lines. From the two vectors it forms one local interrupt, the supervisor-domain external interrupt, at bit 16. That bit is shown in the machine and supervisor pending and enable views. A delegation bit decides whether the supervisor views can see it. In the hypervisor delegation view, bit 16 is hard-wired to zero, so the interrupt can never be handed to a virtual supervisor.

A configuration field picks one of the N controllers. The S-level and VS-level external pending lines of that controller are passed straight to the outputs. The enable vector does not gate them.

Software uses a single-port register interface: address, write data, write enable and combinational read data. Writes take effect at the rising clock edge. Reads show the current state in the same cycle.

Top module: `sd_irq_csr`

## Requirements
- R1: The machine pending view (address 0x0) shows bit 16 as 1 exactly when the bitwise AND of the domain pending inputs and the domain enable vector is nonzero. Output `lsdei_o` carries the same value.
- R2: The machine pending view and the domain pending vector (address 0x6, bits N-1:0) are read-only. The domain pending vector reads the live pending inputs, and writes to either address change no state.
- R3: The supervisor pending view (address 0x2) shows bit 16 as 0 when the delegation bit is clear. When the delegation bit is set, it shows the machine pending bit 16.
- R4: Bit 16 of the machine enable view (address 0x1) is read/write. Bit 16 of the machine delegation view (address 0x4) is read/write.
- R5: The supervisor enable view (address 0x3) aliases machine enable bit 16 when delegated. When not delegated, it reads 0 and writes to it are ignored.
- R6: Bit 16 of the hypervisor delegation view (address 0x5) always reads 0, and writes to it have no effect.
- R7: The domain enable vector (address 0x7, bits N-1:0) is fully read/write, and its upper bits read 0.
- R8: The selector field (address 0x8, bits SELW-1:0, where SELW = clog2(N)+1) picks controller k. The outputs `s_ext_o` and `vs_ext_o` then equal that controller's S-level and VS-level pending inputs, whatever the enable vector holds.
- R9: A selector value of N or above drives `s_ext_o` and `vs_ext_o` low.
- R10: After reset, the enable vector, machine enable bit 16, the delegation bit and the selector are all zero.
- R11: Reads of unmapped addresses (0x9 to 0xF) return 0, and every bit other than those named above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | AW | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable, sampled at the clock edge |
| csr_rdata | output | XLEN | Combinational read data for `csr_addr` |
| sd_pend_i | input | N | Pending line from each domain interrupt controller |
| sd_s_ext_i | input | N | S-level external pending line from each controller |
| sd_vs_ext_i | input | N | VS-level external pending line from each controller |
| lsdei_o | output | 1 | Machine-level domain external interrupt pending |
| s_ext_o | output | 1 | S-level external pending of the selected controller |
| vs_ext_o | output | 1 | VS-level external pending of the selected controller |

## Verification
The bench targets the supervisor enable view written while undelegated. A faulty alias would let that write reach the machine enable bit. It also drives the pending inputs with the enable vector cleared, where a wrong AND-reduce would still raise the interrupt. Selector values at N and above are covered, since a decoder that wraps the index would pick a real controller instead of driving low. Writes of all-ones to the hypervisor delegation and pending views show whether any read-only bit can be set.

// File: rtl/sd_irq_csr.sv
module sd_irq_csr #(
  parameter int N    = 4,
  parameter int XLEN = 32,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [N-1:0]    sd_pend_i,
  input  logic [N-1:0]    sd_s_ext_i,
  input  logic [N-1:0]    sd_vs_ext_i,
  output logic            lsdei_o,
  output logic            s_ext_o,
  output logic            vs_ext_o
);
  localparam int SELW = $clog2(N) + 1;
  localparam int BIT  = 16;
  localparam logic [AW-1:0] A_MPEND  = AW'(0);
  localparam logic [AW-1:0] A_MEN    = AW'(1);
  localparam logic [AW-1:0] A_SPEND  = AW'(2);
  localparam logic [AW-1:0] A_SEN    = AW'(3);
  localparam logic [AW-1:0] A_MDELEG = AW'(4);
  localparam logic [AW-1:0] A_HDELEG = AW'(5);
  localparam logic [AW-1:0] A_DPEND  = AW'(6);
  localparam logic [AW-1:0] A_DEN    = AW'(7);
  localparam logic [AW-1:0] A_SEL    = AW'(8);

  logic [N-1:0]    den;
  logic            m_en;
  logic            m_deleg;
  logic [SELW-1:0] sel;

  assign lsdei_o = |(sd_pend_i & den);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den     <= '0;
      m_en    <= 1'b0;
      m_deleg <= 1'b0;
      sel     <= '0;
    end else if (csr_we) begin
      case (csr_addr)
        A_MEN:    m_en <= csr_wdata[BIT];
        A_SEN:    if (m_deleg) m_en <= csr_wdata[BIT];
        A_MDELEG: m_deleg <= csr_wdata[BIT];
        A_DEN:    den <= csr_wdata[N-1:0];
        A_SEL:    sel <= csr_wdata[SELW-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    s_ext_o  = 1'b0;
    vs_ext_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SELW'(i)) begin
        s_ext_o  = sd_s_ext_i[i];
        vs_ext_o = sd_vs_ext_i[i];
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_MPEND:  csr_rdata[BIT] = lsdei_o;
      A_MEN:    csr_rdata[BIT] = m_en;
      A_SPEND:  csr_rdata[BIT] = m_deleg & lsdei_o;
      A_SEN:    csr_rdata[BIT] = m_deleg & m_en;
      A_MDELEG: csr_rdata[BIT] = m_deleg;
      A_HDELEG: csr_rdata     = '0;
      A_DPEND:  csr_rdata[N-1:0] = sd_pend_i;
      A_DEN:    csr_rdata[N-1:0] = den;
      A_SEL:    csr_rdata[SELW-1:0] = sel;
      default:  csr_rdata = '0;
    endcase
  end

  // R1
  mpend_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_MPEND) |-> (csr_rdata[BIT] == lsdei_o));

  // R3
  spend_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == A_SPEND && !m_deleg) |-> !csr_rdata[BIT]);

  // R5
  sen_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == A_SEN && !m_deleg) |=> $stable(m_en));

  // R7
  den_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == A_DEN) |=> (den == $past(csr_wdata[N-1:0])));

  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= N) |-> (!s_ext_o && !vs_ext_o));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (den == '0 && !m_en && !m_deleg && sel == '0));
endmodule

// File: tb/sd_irq_csr_tb.sv
`timescale 1ns/100ps
module sd_irq_csr_tb;
  localparam int N = 4, XLEN = 32, AW = 4, SELW = 3;

  logic clk = 1'b0, rst_n = 1'b0, csr_we = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0, csr_rdata;
  logic [N-1:0] sd_pend_i = '0, sd_s_ext_i = '0, sd_vs_ext_i = '0;
  logic lsdei_o, s_ext_o, vs_ext_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [N-1:0] m_den;
  logic m_men, m_dlg;
  logic [SELW-1:0] m_sel;

  always #4 clk = ~clk;

  sd_irq_csr #(.N(N), .XLEN(XLEN), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .sd_pend_i(sd_pend_i),
    .sd_s_ext_i(sd_s_ext_i), .sd_vs_ext_i(sd_vs_ext_i), .lsdei_o(lsdei_o),
    .s_ext_o(s_ext_o), .vs_ext_o(vs_ext_o));

  function automatic logic [XLEN-1:0] exp_rd(input int a);
    logic [XLEN-1:0] r = '0;
    logic p = |(sd_pend_i & m_den);
    case (a)
      0: r[16] = p;
      1: r[16] = m_men;
      2: r[16] = m_dlg & p;
      3: r[16] = m_dlg & m_men;
      4: r[16] = m_dlg;
      6: r[N-1:0] = sd_pend_i;
      7: r[N-1:0] = m_den;
      8: r[SELW-1:0] = m_sel;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag(input int a);
    case (a)
      0: return "R1";
      1: return "R4";
      2: return "R3";
      3: return "R5";
      4: return "R4";
      5: return "R6";
      6: return "R2";
      7: return "R7";
      8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string r, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_addr = AW'(a); csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    case (a)
      1: m_men = d[16];
      3: if (m_dlg) m_men = d[16];
      4: m_dlg = d[16];
      7: m_den = d[N-1:0];
      8: m_sel = d[SELW-1:0];
      default: ;
    endcase
  endtask

  task automatic check_all();
    logic es, ev;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      csr_addr = AW'(a);
      #1;
      chk(tag(a), csr_rdata, exp_rd(a));
    end
    chk("R1", {31'd0, lsdei_o}, {31'd0, |(sd_pend_i & m_den)});
    es = (int'(m_sel) < N) ? sd_s_ext_i[m_sel[1:0]] : 1'b0;
    ev = (int'(m_sel) < N) ? sd_vs_ext_i[m_sel[1:0]] : 1'b0;
    chk((int'(m_sel) < N) ? "R8" : "R9", {30'd0, s_ext_o, vs_ext_o}, {30'd0, es, ev});
  endtask

  initial begin
    m_den = '0; m_men = 1'b0; m_dlg = 1'b0; m_sel = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    sd_pend_i = '1; sd_s_ext_i = 4'b0001; sd_vs_ext_i = 4'b0001;
    check_all();
    chk("R10", csr_rdata, '0);
    // R2 writes to read-only pending views
    wr(7, 32'h0);
    wr(0, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    sd_pend_i = 4'b0000;
    check_all();
    // R6 hypervisor delegation stays zero
    wr(5, 32'hFFFF_FFFF);
    check_all();
    // R5 undelegated supervisor enable write ignored
    wr(3, 32'h0001_0000);
    check_all();
    wr(4, 32'h0001_0000);
    wr(3, 32'h0001_0000);
    sd_pend_i = 4'b0100; wr(7, 32'hFFFF_FFF4);
    check_all();
    // R9 selector out of range
    sd_s_ext_i = '1; sd_vs_ext_i = '1;
    for (int s = 4; s < 8; s++) begin wr(8, 32'(s)); check_all(); end
    // R8 enable vector does not gate selected lines
    wr(7, 32'h0);
    for (int s = 0; s < 4; s++) begin
      sd_s_ext_i = 4'(1 << s); sd_vs_ext_i = ~4'(1 << s);
      wr(8, 32'(s)); check_all();
    end
    for (int it = 0; it < 300; it++) begin
      int a;
      sd_pend_i = 4'($urandom); sd_s_ext_i = 4'($urandom); sd_vs_ext_i = 4'($urandom);
      a = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 9);
      wr(a, $urandom);
      check_all();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule